// File: doc/BRIEF.md
# Unbiased Round-to-Hundred Unit

This unit takes an unsigned binary integer and returns the multiple of one hundred closest to it. When the input lies exactly halfway between two hundreds, it rounds to the hundred whose hundreds count is even. Rounding half up from the remainder modulo 100 would favour the upper neighbour on every tie. This unit does not. Instead it works out the remainder modulo 200 (`r`), which shows whether the lower hundred is even or odd. From that remainder it picks one of three candidates: `base = x - r`, `base + 100` or `base + 200`.

The remainder comes from splitting the input into 4-bit groups. Each group addresses a small table of constant residues, the group outputs are summed, and a fixed chain of conditional subtractions reduces the sum. There are no division circuits. One register stage follows the selection, so each accepted input produces a result on the next cycle. Inputs may arrive on every cycle. If the chosen multiple would not fit in the output width, the unit raises an overflow flag and returns the largest representable multiple of one hundred instead.

Top module: `round_hundred_even`

## Requirements
- R1: With `inValid` high, for `r = inValue mod 200` not equal to 50 or 150, `outValue` is the multiple of 100 closest to `inValue`. The rule is `base` for `r < 50`, `base+100` for `50 < r < 150`, and `base+200` for `r > 150`.
- R2: When `r` equals 50 (for example 1250), the result is `base` (1200), which is the even hundred below.
- R3: When `r` equals 150 (for example 1150), the result is `base+200` (1200), which is the even hundred above.
- R4: `outValid` is high on the cycle after each cycle in which `inValid` was high, and low after each cycle in which it was low. Back-to-back inputs give back-to-back results.
- R5: While `inValid` is low, `outValue` and `outOverflow` keep their last values.
- R6: If the selected multiple exceeds 2^32-1, `outOverflow` is 1 and `outValue` is 4294967200. Otherwise `outOverflow` is 0.
- R7: While `rstN` is low, and on the first cycle after release without input, `outValid`, `outValue` and `outOverflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word is present this cycle |
| inValue | input | 32 | Unsigned value to round |
| outValid | output | 1 | Result present this cycle |
| outValue | output | 32 | Rounded value, a multiple of 100 |
| outOverflow | output | 1 | Rounded value was saturated |

## Verification
The assertions assume that `inValue` is a known value whenever `inValid` is high. They compare the table-derived remainder with a plain modulo only on cycles that capture an input. The bench drives `inValue` only together with a valid strobe, at the falling edge. It holds reset until the clock is running, so every checked cycle follows a defined capture or idle cycle. The stimulus covers ties at 50 and 150 across many hundreds, the values one above and one below each tie, the top of the range where saturation applies, and random words both back to back and with idle gaps.

// File: rtl/round_hundred_pkg.sv
package round_hundred_pkg;
  // Strobes the controller hands to the datapath each cycle.
  typedef struct packed {
    logic capture;
  } rnd_strobe_t;
endpackage

// File: rtl/rnd_residue.sv
// Grouped-table residue: value mod MOD without division.
module rnd_residue #(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 4,
  parameter int MOD     = 200,
  localparam int RES_W  = $clog2(MOD)
) (
  input  logic [DATA_W-1:0] value,
  output logic [RES_W-1:0]  residue
);
  localparam int NGRP   = (DATA_W + GROUP_W - 1) / GROUP_W;
  localparam int PAD_W  = NGRP * GROUP_W;
  localparam int SUM_W  = $clog2(NGRP * MOD + 1);
  localparam int STEPS  = $clog2(NGRP);
  localparam int ENTRIES = 2 ** GROUP_W;

  // Weight of group i: 2^(GROUP_W*i) mod MOD, folded step by step.
  function automatic int groupWeight(input int idx);
    int w;
    w = 1 % MOD;
    for (int k = 0; k < idx * GROUP_W; k++) w = (w * 2) % MOD;
    return w;
  endfunction

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(value);

  logic [RES_W-1:0] groupRes [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : gGroup
    localparam int WEIGHT = groupWeight(g);
    logic [RES_W-1:0] lut [ENTRIES];
    always_comb begin
      for (int e = 0; e < ENTRIES; e++) lut[e] = RES_W'((e * WEIGHT) % MOD);
    end
    assign groupRes[g] = lut[padded[g*GROUP_W +: GROUP_W]];
  end

  logic [SUM_W-1:0] total;
  always_comb begin
    total = '0;
    for (int g = 0; g < NGRP; g++) total = total + SUM_W'(groupRes[g]);
  end

  // total < NGRP*MOD <= MOD*2^STEPS: subtract MOD*2^k from the top down.
  logic [SUM_W-1:0] acc;
  always_comb begin
    acc = total;
    for (int k = STEPS - 1; k >= 0; k--) begin
      if (acc >= SUM_W'(MOD << k)) acc = acc - SUM_W'(MOD << k);
    end
    residue = RES_W'(acc);
  end
endmodule

// File: rtl/rnd_ctrl.sv
module rnd_ctrl
  import round_hundred_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output rnd_strobe_t strobe,
  output logic        outValid
);
  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R4
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/rnd_datapath.sv
module rnd_datapath
  import round_hundred_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 4,
  parameter int STEP    = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  rnd_strobe_t       strobe,
  input  logic [DATA_W-1:0] inValue,
  output logic [DATA_W-1:0] resultQ,
  output logic              ovfQ
);
  localparam int MOD   = 2 * STEP;
  localparam int HALF  = STEP / 2;
  localparam int UPPER = STEP + HALF;
  localparam int RES_W = $clog2(MOD);
  localparam int EXT_W = DATA_W + 1;
  localparam logic [EXT_W-1:0] MAXV = {1'b0, {DATA_W{1'b1}}};
  localparam logic [DATA_W-1:0] SAT = DATA_W'((MAXV / EXT_W'(STEP)) * EXT_W'(STEP));

  logic [RES_W-1:0] rem;

  rnd_residue #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .MOD(MOD)) u_residue (
    .value  (inValue),
    .residue(rem)
  );

  logic [EXT_W-1:0] base, pick;
  logic             overflow;
  logic [DATA_W-1:0] rounded;

  always_comb begin
    base = EXT_W'(inValue) - EXT_W'(rem);
    if (rem <= RES_W'(HALF))      pick = base;
    else if (rem < RES_W'(UPPER)) pick = base + EXT_W'(STEP);
    else                          pick = base + EXT_W'(MOD);
    overflow = pick > MAXV;
    rounded  = overflow ? SAT : pick[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      ovfQ    <= 1'b0;
    end else if (strobe.capture) begin
      resultQ <= rounded;
      ovfQ    <= overflow;
    end
  end

  // R1
  residue_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (32'(rem) == 32'(inValue % DATA_W'(MOD))));
  // R1
  nearest_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (ovfQ ||
      ((resultQ >= $past(inValue)) ? (resultQ - $past(inValue)) <= DATA_W'(HALF)
                                   : ($past(inValue) - resultQ) <= DATA_W'(HALF))));
  // R1
  multiple_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultQ % DATA_W'(STEP)) == '0);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |-> resultQ == SAT);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(resultQ) && $stable(ovfQ)));
endmodule

// File: rtl/round_hundred_even.sv
module round_hundred_even
  import round_hundred_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 4,
  parameter int STEP    = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inValue,
  output logic              outValid,
  output logic [DATA_W-1:0] outValue,
  output logic              outOverflow
);
  rnd_strobe_t strobe;

  rnd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  rnd_datapath #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .STEP(STEP)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inValue(inValue),
    .resultQ(outValue),
    .ovfQ   (outOverflow)
  );
endmodule

// File: tb/test_round_hundred_even.sv
module test_round_hundred_even;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inValue = '0;
  logic        outValid;
  logic [31:0] outValue;
  logic        outOverflow;

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    logic [31:0] val;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t scoreQ[$];
  logic [31:0] lastVal = '0;
  logic        lastOvf = 1'b0;

  always #10 clk = ~clk;

  round_hundred_even i_round_hundred_even (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inValue(inValue),
    .outValid(outValid), .outValue(outValue), .outOverflow(outOverflow)
  );

  function automatic exp_t model(input logic [31:0] x);
    exp_t e;
    longint unsigned r, b, c;
    r = longint'(x) % 200;
    b = longint'(x) - r;
    if (r <= 50)      c = b;
    else if (r < 150) c = b + 100;
    else              c = b + 200;
    e.ovf = c > 64'hFFFF_FFFF;
    e.val = e.ovf ? 32'd4294967200 : c[31:0];
    if (e.ovf)         e.tag = "R6";
    else if (r == 50)  e.tag = "R2";
    else if (r == 150) e.tag = "R3";
    else               e.tag = "R1";
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] x);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1;
    inValue = x;
    e = model(x);
    scoreQ.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      // R5: held outputs, R4: no result without input
      check("R4", 32'(outValid), 32'd0);
      check("R5", outValue, lastVal);
      check("R5", 32'(outOverflow), 32'(lastOvf));
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (scoreQ.size() == 0) begin
        check("R4", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = scoreQ.pop_front();
        check(e.tag, outValue, e.val);
        check(e.tag, 32'(outOverflow), 32'(e.ovf));
        lastVal = e.val;
        lastOvf = e.ovf;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", 32'(outValid), 32'd0);
    check("R7", outValue, 32'd0);
    check("R7", 32'(outOverflow), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R7", 32'(outValid), 32'd0);
    check("R7", outValue, 32'd0);

    // R2 / R3 named examples
    send(32'd1250);
    send(32'd1150);
    send(32'd0);
    send(32'd50);
    send(32'd150);
    idle(2);

    // ties and neighbours across many hundreds
    for (int k = 0; k < 60; k++) begin
      logic [31:0] b;
      b = 32'(k * 7919 * 200);
      send(b + 49); send(b + 50); send(b + 51);
      send(b + 149); send(b + 150); send(b + 151);
      send(b + 199); send(b + 100);
    end
    idle(3);

    // top of range, R6 saturation
    send(32'd4294967295);
    send(32'd4294967249);
    send(32'd4294967250);
    send(32'd4294967251);
    send(32'd4294967150);
    send(32'd4294967199);
    idle(2);

    // random, mixed with gaps
    for (int i = 0; i < 2000; i++) begin
      send($urandom);
      if (($urandom % 16) == 0) idle(1 + ($urandom % 3));
    end
    idle(3);

    // R4: every pushed item consumed
    check("R4", 32'(scoreQ.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule